// File: doc/BRIEF.md
# Resume Register-Restore Script Engine

This block replays a byte-coded list of register writes when the system comes back from a sleep state. Firmware leaves a script in a small byte-wide memory. A single start pulse makes the engine walk that script from offset 0. For each variable-length entry it reads the header and decodes the opcode. It then issues I/O-port, memory or configuration-space writes and read-modify-writes on a generic register bus. Stall entries wait a given number of clocks, and informational entries are skipped. Entries that would hand control to code (dispatch), bus-protocol transactions and unknown opcodes are never executed. They stop the engine with an error flag and the offset of the offending entry.

The script memory is a plain synchronous read port. The engine raises a read enable with a byte address, and the byte comes back on the next clock. The register bus carries a valid/ready request channel. A request stays stable, with valid high, until ready is seen high at a clock edge; the engine never withdraws a request. A read request is answered later by a single-cycle response strobe that carries the data. The engine has only one request outstanding and waits for that strobe before it issues anything else. The response has no back-pressure. The script length must not exceed the script memory size (2^SA_W bytes).

Top module: `rrs_engine`

## Requirements
- R1: Every entry starts with byte 0 = opcode, byte 1 = width code and byte 2 = total entry length in bytes. Execution starts at offset 0, and the next entry starts at the current offset plus that length.
- R2: For bus opcodes (0x00 to 0x05), width codes 0, 1, 2 and 3 select 1-, 2-, 4- and 8-byte accesses; req_size_o carries the code. Any other width code on a bus opcode raises the error.
- R3: Opcodes 0x00, 0x02 and 0x04 are writes to I/O (req_space_o = 0), memory (1) and configuration space (2). Bytes 3..6 hold the start address and byte 7 holds the repeat count. From byte 8 on come that many values of access size each. The values are issued in order, and the address advances by the access size after each one. All multi-byte fields are little-endian.
- R4: Opcodes 0x01, 0x03 and 0x05 are read-modify-writes in the same three spaces. Bytes 3..6 hold the address, byte 7 starts the value and the mask follows the value; both are of access size. The engine makes one bus read and then writes (read AND mask) OR value to the same address and size.
- R5: Write data bits above the access size are zero.
- R6: Opcode 0x07 is a stall. Bytes 3..6 hold a 32-bit count, and the entry takes exactly count clocks longer than a stall of count 0, with no bus request meanwhile.
- R7: Opcode 0x0A is informational: it is skipped with no bus request.
- R8: The script ends when an opcode 0xFF is met, or when the next entry offset is at or beyond script_len_i. done_o then rises and stays high until the next accepted start.
- R9: Opcodes 0x06, 0x08, 0x09 and every other unlisted value, an invalid width on a bus opcode, and an entry length below 3 all halt the engine. err_o rises and err_off_o gives the entry offset. That entry makes no bus request, and err_o stays high until the next accepted start.
- R10: A bus request is held with unchanged address, data and direction until req_ready_i is high at an edge.
- R11: After reset, done_o, err_o and req_valid_o are low. A start pulse is accepted only while the engine is idle; a start during a run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle start pulse |
| script_len_i | input | SA_W+1 | Script length in bytes |
| sm_rd_en_o | output | 1 | Script memory read enable |
| sm_addr_o | output | SA_W | Script memory byte address |
| sm_data_i | input | 8 | Script byte, one clock after the read enable |
| req_valid_o | output | 1 | Bus request valid |
| req_ready_i | input | 1 | Bus request accepted |
| req_write_o | output | 1 | 1 = write, 0 = read |
| req_space_o | output | 2 | 0 I/O, 1 memory, 2 configuration |
| req_size_o | output | 2 | Access width code |
| req_addr_o | output | AW | Bus address |
| req_wdata_o | output | DW | Write data |
| rsp_valid_i | input | 1 | Read response strobe |
| rsp_data_i | input | DW | Read response data |
| done_o | output | 1 | Script finished |
| err_o | output | 1 | Script halted on a bad entry |
| err_off_o | output | SA_W | Offset of the bad entry |

## Verification
The embedded properties assume three things about the inputs. Script memory data is valid exactly one clock after a read enable. A response strobe arrives only once per accepted read and never unprompted. start_i is a pulse. The bench memory model has that fixed latency, and its bus model answers each accepted read exactly two clocks later. The bus model also throttles ready in a repeating pattern, so the rule that requests are held under back-pressure is exercised throughout. Sweeps cover every bus opcode against every width code and several repeat counts, and the expected bus traffic is derived arithmetically in the bench.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  localparam logic [7:0] OP_STALL = 8'h07;
  localparam logic [7:0] OP_INFO  = 8'h0A;
  localparam logic [7:0] OP_END   = 8'hFF;
  localparam logic [7:0] OP_BUSMX = 8'h05;

  typedef enum logic [3:0] {
    S_IDLE, S_CHK, S_HDR, S_DEC, S_ADDR, S_CNT, S_DATA,
    S_WR, S_VAL, S_MASK, S_RD, S_RWAIT, S_STALL, S_NEXT
  } eng_state_e;

  function automatic logic [3:0] access_bytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction
endpackage

// File: rtl/rrs_fetch.sv
module rrs_fetch #(
  parameter int SA_W = 8,
  parameter int DW   = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go_i,
  input  logic [SA_W-1:0] base_i,
  input  logic [3:0]      nbytes_i,
  output logic            rd_en_o,
  output logic [SA_W-1:0] rd_addr_o,
  input  logic [7:0]      rd_data_i,
  output logic            done_o,
  output logic [DW-1:0]   value_o
);
  logic            busy;
  logic            pend;
  logic [3:0]      iss, cap, n_q;
  logic [SA_W-1:0] base_q;

  assign rd_en_o   = busy && (iss < n_q);
  assign rd_addr_o = base_q + SA_W'(iss);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; pend <= 1'b0; iss <= '0; cap <= '0; n_q <= '0;
      base_q <= '0; done_o <= 1'b0; value_o <= '0;
    end else begin
      done_o <= 1'b0;
      pend   <= rd_en_o;
      if (go_i && !busy) begin
        busy <= 1'b1; iss <= '0; cap <= '0; n_q <= nbytes_i;
        base_q <= base_i; value_o <= '0;
      end else if (busy) begin
        if (rd_en_o) iss <= iss + 4'd1;
        if (pend) begin
          value_o <= value_o | (DW'(rd_data_i) << {cap, 3'b000});
          cap     <= cap + 4'd1;
          if (cap == n_q - 4'd1) begin
            busy   <= 1'b0;
            done_o <= 1'b1;
          end
        end
      end
    end
  end

  // little-endian assembly never captures a byte that was not requested
  p_capture_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cap <= iss);
endmodule

// File: rtl/rrs_merge.sv
module rrs_merge #(
  parameter int DW = 64
) (
  input  logic [1:0]    size_i,
  input  logic          is_rmw_i,
  input  logic [DW-1:0] rd_i,
  input  logic [DW-1:0] val_i,
  input  logic [DW-1:0] mask_i,
  output logic [DW-1:0] res_o
);
  logic [7:0]    sh;
  logic [DW-1:0] keep;

  always_comb begin
    sh    = 8'd8 << size_i;
    keep  = ~({DW{1'b1}} << sh);
    res_o = (is_rmw_i ? ((rd_i & mask_i) | val_i) : val_i) & keep;
    if (size_i == 2'd0) begin
      p_upper_zero_r5: assert (res_o[DW-1:8] == '0);
    end
  end
endmodule

// File: rtl/rrs_stall.sv
module rrs_stall #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] count_i,
  output logic          busy_o
);
  logic [CW-1:0] cnt;

  assign busy_o = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load_i)      cnt <= count_i;
    else if (cnt != '0)   cnt <= cnt - CW'(1);
  end
endmodule

// File: rtl/rrs_engine.sv
module rrs_engine #(
  parameter int SA_W = 8,
  parameter int AW   = 32,
  parameter int DW   = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [SA_W:0]   script_len_i,
  output logic            sm_rd_en_o,
  output logic [SA_W-1:0] sm_addr_o,
  input  logic [7:0]      sm_data_i,
  output logic            req_valid_o,
  input  logic            req_ready_i,
  output logic            req_write_o,
  output logic [1:0]      req_space_o,
  output logic [1:0]      req_size_o,
  output logic [AW-1:0]   req_addr_o,
  output logic [DW-1:0]   req_wdata_o,
  input  logic            rsp_valid_i,
  input  logic [DW-1:0]   rsp_data_i,
  output logic            done_o,
  output logic            err_o,
  output logic [SA_W-1:0] err_off_o
);
  import rrs_pkg::*;

  eng_state_e      state;
  logic [SA_W:0]   off;
  logic [7:0]      op, wc, elen, cnt, idx;
  logic [AW-1:0]   addr;
  logic [SA_W-1:0] ptr, offl;
  logic [DW-1:0]   val, mask, rdv;
  logic            f_iss, f_go, f_done, in_fetch, st_load, st_busy;
  logic [SA_W-1:0] f_base;
  logic [3:0]      f_n, sz;
  logic [DW-1:0]   f_val;

  assign offl     = off[SA_W-1:0];
  assign sz       = access_bytes(wc[1:0]);
  assign in_fetch = state inside {S_HDR, S_ADDR, S_CNT, S_DATA, S_VAL, S_MASK};
  assign f_go     = in_fetch && !f_iss;
  assign st_load  = (state == S_ADDR) && f_done && (op == OP_STALL);

  always_comb begin
    f_base = offl;
    f_n    = 4'd3;
    case (state)
      S_ADDR: begin f_base = offl + SA_W'(3); f_n = 4'd4; end
      S_CNT:  begin f_base = offl + SA_W'(7); f_n = 4'd1; end
      S_DATA: begin f_base = ptr;             f_n = sz;   end
      S_VAL:  begin f_base = offl + SA_W'(7); f_n = sz;   end
      S_MASK: begin f_base = offl + SA_W'(7) + SA_W'(sz); f_n = sz; end
      default: ;
    endcase
  end

  rrs_fetch #(.SA_W(SA_W), .DW(DW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .go_i(f_go), .base_i(f_base), .nbytes_i(f_n),
    .rd_en_o(sm_rd_en_o), .rd_addr_o(sm_addr_o), .rd_data_i(sm_data_i),
    .done_o(f_done), .value_o(f_val));

  rrs_merge #(.DW(DW)) u_merge (
    .size_i(wc[1:0]), .is_rmw_i(op[0]), .rd_i(rdv), .val_i(val),
    .mask_i(mask), .res_o(req_wdata_o));

  rrs_stall #(.CW(32)) u_stall (
    .clk(clk), .rst_n(rst_n), .load_i(st_load), .count_i(f_val[31:0]),
    .busy_o(st_busy));

  assign req_valid_o = (state == S_WR) || (state == S_RD);
  assign req_write_o = (state == S_WR);
  assign req_space_o = op[2:1];
  assign req_size_o  = wc[1:0];
  assign req_addr_o  = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; off <= '0; op <= '0; wc <= '0; elen <= '0;
      cnt <= '0; idx <= '0; addr <= '0; ptr <= '0; val <= '0;
      mask <= '0; rdv <= '0; f_iss <= 1'b0;
      done_o <= 1'b0; err_o <= 1'b0; err_off_o <= '0;
    end else begin
      if (f_go)   f_iss <= 1'b1;
      if (f_done) f_iss <= 1'b0;
      case (state)
        S_IDLE: if (start_i) begin
          done_o <= 1'b0; err_o <= 1'b0; off <= '0; state <= S_CHK;
        end
        S_CHK: if (off >= script_len_i) begin
          done_o <= 1'b1; state <= S_IDLE;
        end else state <= S_HDR;
        S_HDR: if (f_done) begin
          op <= f_val[7:0]; wc <= f_val[15:8]; elen <= f_val[23:16];
          state <= S_DEC;
        end
        S_DEC: begin
          if (op == OP_END) begin
            done_o <= 1'b1; state <= S_IDLE;
          end else if ((elen >= 8'd3) && (op <= OP_BUSMX) && (wc <= 8'd3))
            state <= S_ADDR;
          else if ((elen >= 8'd3) && (op == OP_STALL))
            state <= S_ADDR;
          else if ((elen >= 8'd3) && (op == OP_INFO))
            state <= S_NEXT;
          else begin
            err_o <= 1'b1; err_off_o <= offl; state <= S_IDLE;
          end
        end
        S_ADDR: if (f_done) begin
          addr <= f_val[AW-1:0]; cnt <= 8'd1; idx <= '0;
          if (op == OP_STALL) state <= S_STALL;
          else if (op[0])     state <= S_VAL;
          else                state <= S_CNT;
        end
        S_CNT: if (f_done) begin
          cnt   <= f_val[7:0];
          ptr   <= offl + SA_W'(8);
          state <= (f_val[7:0] == 8'd0) ? S_NEXT : S_DATA;
        end
        S_DATA: if (f_done) begin val <= f_val; state <= S_WR; end
        S_WR: if (req_ready_i) begin
          idx   <= idx + 8'd1;
          addr  <= addr + AW'(sz);
          ptr   <= ptr + SA_W'(sz);
          state <= (idx + 8'd1 == cnt) ? S_NEXT : S_DATA;
        end
        S_VAL:   if (f_done) begin val <= f_val; state <= S_MASK; end
        S_MASK:  if (f_done) begin mask <= f_val; state <= S_RD; end
        S_RD:    if (req_ready_i) state <= S_RWAIT;
        S_RWAIT: if (rsp_valid_i) begin rdv <= rsp_data_i; state <= S_WR; end
        S_STALL: if (!st_busy) state <= S_NEXT;
        S_NEXT: begin
          off <= off + (SA_W+1)'(elen); state <= S_CHK;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o)
      && $stable(req_wdata_o) && $stable(req_write_o));
  p_flag_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));
  p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o && !start_i |=> err_o);
  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> done_o);
  p_quiet_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st_busy |-> !req_valid_o);
endmodule

// File: tb/rrs_engine_test.sv
module rrs_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [8:0]  script_len = '0;
  logic        sm_rd_en;
  logic [7:0]  sm_addr;
  logic [7:0]  sm_data = '0;
  logic        req_valid, req_write;
  logic        req_ready = 1'b0;
  logic [1:0]  req_space, req_size;
  logic [31:0] req_addr;
  logic [63:0] req_wdata;
  logic        rsp_valid = 1'b0;
  logic [63:0] rsp_data = '0;
  logic        done, err;
  logic [7:0]  err_off;

  always #4 clk = ~clk;

  rrs_engine uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .script_len_i(script_len),
    .sm_rd_en_o(sm_rd_en), .sm_addr_o(sm_addr), .sm_data_i(sm_data),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_write_o(req_write),
    .req_space_o(req_space), .req_size_o(req_size), .req_addr_o(req_addr),
    .req_wdata_o(req_wdata), .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data),
    .done_o(done), .err_o(err), .err_off_o(err_off));

  logic [7:0]  mem [256];
  int total = 0, bad = 0, cyc = 0, nlog = 0, nrd = 0, pend_rd = 0;
  logic [1:0]  lg_sp [64]; logic [31:0] lg_a [64];
  logic [1:0]  lg_sz [64]; logic [63:0] lg_d [64];
  logic [1:0]  ex_sp [64]; logic [31:0] ex_a [64];
  logic [1:0]  ex_sz [64]; logic [63:0] ex_d [64];
  int nexp = 0, wp = 0;
  logic [31:0] rd_a = '0; logic [1:0] rd_s = '0;
  bit finished = 0;

  function automatic logic [63:0] rmodel(input logic [1:0] s, input logic [31:0] a);
    return {a ^ 32'h5A5A_F00F, a * 32'd13 + 32'(s)};
  endfunction
  function automatic logic [63:0] kp(input logic [1:0] w);
    return (w == 2'd3) ? '1 : ((64'd1 << (8 << w)) - 64'd1);
  endfunction

  always @(posedge clk) sm_data <= sm_rd_en ? mem[sm_addr] : 8'h00;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    req_ready <= (cyc % 3) != 1;
    rsp_valid <= 1'b0;
    if (pend_rd != 0) pend_rd <= pend_rd - 1;
    if (pend_rd == 1) begin rsp_valid <= 1'b1; rsp_data <= rmodel(rd_s, rd_a); end
    if (req_valid && req_ready) begin
      if (req_write) begin
        if (nlog < 64) begin
          lg_sp[nlog] = req_space; lg_a[nlog] = req_addr;
          lg_sz[nlog] = req_size;  lg_d[nlog] = req_wdata;
        end
        nlog = nlog + 1;
      end else begin
        pend_rd <= 2; rd_a <= req_addr; rd_s <= req_space; nrd = nrd + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic newscript(); wp = 0; nexp = 0; endtask
  task automatic pb(input logic [7:0] b); mem[wp] = b; wp++; endtask
  task automatic ple(input logic [63:0] v, input int n);
    for (int k = 0; k < n; k++) pb(v[8*k +: 8]);
  endtask
  task automatic expw(input logic [1:0] s, input logic [31:0] a, input logic [1:0] w,
                      input logic [63:0] d);
    ex_sp[nexp] = s; ex_a[nexp] = a; ex_sz[nexp] = w; ex_d[nexp] = d; nexp++;
  endtask

  task automatic put_wr(input logic [7:0] op, input logic [1:0] w,
                        input logic [31:0] a, input int cnt);
    int sz = 1 << w;
    pb(op); pb({6'd0, w}); pb(8'(8 + cnt * sz)); ple(64'(a), 4); pb(8'(cnt));
    for (int i = 0; i < cnt; i++) begin
      logic [63:0] v = 64'h8877_6655_4433_2211 + 64'(i + 1) * 64'h1111_1111_1111_1111
                       * 64'(op + 1);
      ple(v, sz);
      expw(op[2:1], a + 32'(i * sz), w, v & kp(w));
    end
  endtask

  task automatic put_rmw(input logic [7:0] op, input logic [1:0] w, input logic [31:0] a,
                         input logic [63:0] v, input logic [63:0] m);
    int sz = 1 << w;
    pb(op); pb({6'd0, w}); pb(8'(7 + 2 * sz)); ple(64'(a), 4); ple(v, sz); ple(m, sz);
    expw(op[2:1], a, w, ((rmodel(op[2:1], a) & m) | v) & kp(w));
  endtask

  task automatic put_stall(input int n);
    pb(8'h07); pb(8'h00); pb(8'd7); ple(64'(n), 4);
  endtask
  task automatic put_info(input int len);
    pb(8'h0A); pb(8'h00); pb(8'(len));
    for (int i = 3; i < len; i++) pb(8'hEE);
  endtask

  task automatic run(input int slen, input int extra_at, output int cycles);
    @(negedge clk);
    nlog = 0; nrd = 0; script_len = 9'(slen); start = 1'b1;
    @(negedge clk); start = 1'b0; cycles = 1;
    while (!(done || err) && cycles < 4000) begin
      @(negedge clk); cycles++;
      start = (cycles == extra_at);
    end
    start = 1'b0;
  endtask

  task automatic cmp_log(input string tag);
    chk({tag, " write count"}, 64'(nlog), 64'(nexp));
    for (int i = 0; i < nexp && i < nlog; i++) begin
      chk($sformatf("%s wr%0d space", tag, i), 64'(lg_sp[i]), 64'(ex_sp[i]));
      chk($sformatf("%s wr%0d addr", tag, i), 64'(lg_a[i]), 64'(ex_a[i]));
      chk($sformatf("%s wr%0d size", tag, i), 64'(lg_sz[i]), 64'(ex_sz[i]));
      chk($sformatf("%s wr%0d data", tag, i), lg_d[i], ex_d[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c, c0;
    repeat (3) @(negedge clk);
    chk("R11 reset done", 64'(done), 0);
    chk("R11 reset err", 64'(err), 0);
    chk("R11 reset req_valid", 64'(req_valid), 0);
    rst_n = 1'b1;

    // R3 R5 R2: every write opcode against every width and counts 1..3
    foreach (ex_d[j]) ex_d[j] = '0;
    for (int op = 0; op <= 4; op += 2)
      for (int w = 0; w < 4; w++)
        for (int n = 1; n <= 3; n++) begin
          newscript();
          put_wr(8'(op), 2'(w), 32'h1000_0000 + 32'(op * 256 + w * 16), n);
          run(wp, -1, c);
          cmp_log($sformatf("R3 op%0d w%0d n%0d", op, w, n));
          chk("R8 done after length end", 64'(done), 1);
        end

    // R4 R5: every read-modify-write opcode against every width
    for (int op = 1; op <= 5; op += 2)
      for (int w = 0; w < 4; w++) begin
        newscript();
        put_rmw(8'(op), 2'(w), 32'h0000_0430 + 32'(op * 8 + w),
                64'h0000_0021_0000_0021 ^ 64'(w), 64'hFFFF_FFDE_FFFF_FFDE ^ 64'(op << 8));
        run(wp, -1, c);
        chk($sformatf("R4 op%0d w%0d reads", op, w), 64'(nrd), 1);
        cmp_log($sformatf("R4 op%0d w%0d", op, w));
      end

    // R1 R7 R8: chained entries, info skip, end marker stops before a dispatch entry
    newscript();
    put_wr(8'h02, 2'd1, 32'h2000_0000, 2);
    put_info(6);
    put_rmw(8'h01, 2'd2, 32'h0000_0430, 64'h21, 64'hFFFF_FFDE);
    put_wr(8'h04, 2'd3, 32'h0008_0000, 1);
    pb(8'hFF); pb(8'h00); pb(8'h03);
    pb(8'h08); pb(8'h00); pb(8'h10);
    run(200, -1, c);
    chk("R1 chain reads", 64'(nrd), 1);
    cmp_log("R1 chain");
    chk("R8 end marker done", 64'(done), 1);
    chk("R8 end marker err", 64'(err), 0);

    // R2 R9: invalid width after a valid entry
    newscript();
    put_wr(8'h00, 2'd0, 32'h0000_0080, 1);
    pb(8'h02); pb(8'h05); pb(8'd9); ple(64'h10, 4); pb(8'd1); pb(8'h55);
    run(wp, -1, c);
    chk("R2 bad width err", 64'(err), 1);
    chk("R2 bad width offset", 64'(err_off), 9);
    chk("R2 bad width done", 64'(done), 0);
    cmp_log("R2 bad width");

    // R9: halting opcodes, each after an info entry of 4 bytes
    foreach (ex_a[j]) ex_a[j] = '0;
    begin
      logic [7:0] bad_ops [7] = '{8'h06, 8'h08, 8'h09, 8'h0B, 8'h10, 8'h80, 8'hFE};
      for (int k = 0; k < 7; k++) begin
        newscript();
        put_info(4);
        pb(bad_ops[k]); pb(8'h00); pb(8'd16); ple(64'h1234, 13);
        run(wp, -1, c);
        chk($sformatf("R9 op%h err", bad_ops[k]), 64'(err), 1);
        chk($sformatf("R9 op%h offset", bad_ops[k]), 64'(err_off), 4);
        chk($sformatf("R9 op%h traffic", bad_ops[k]), 64'(nlog + nrd), 0);
      end
    end
    newscript();
    pb(8'h00); pb(8'h00); pb(8'd2); pb(8'h00);
    run(wp + 10, -1, c);
    chk("R9 short length err", 64'(err), 1);
    chk("R9 short length traffic", 64'(nlog + nrd), 0);

    // R8: empty script, and R11 err cleared by a new start
    newscript();
    run(0, -1, c);
    chk("R8 empty done", 64'(done), 1);
    chk("R11 err cleared on start", 64'(err), 0);

    // R6: stall timing relative to count 0
    newscript(); put_stall(0);
    run(wp, -1, c0);
    newscript(); put_stall(5);
    run(wp, -1, c);
    chk("R6 stall 5 extra cycles", 64'(c - c0), 5);
    chk("R6 stall traffic", 64'(nlog + nrd), 0);
    newscript(); put_stall(37);
    run(wp, -1, c);
    chk("R6 stall 37 extra cycles", 64'(c - c0), 37);

    // R11: start during a run is ignored
    newscript(); put_stall(37);
    run(wp, 10, c);
    chk("R11 restart ignored", 64'(c - c0), 37);
    chk("R11 restart done", 64'(done), 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule